// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Flag Unit

This block holds the fixed-point status flags of a 64-bit integer datapath. It keeps a sticky summary-overflow bit, the full-width overflow and carry bits, and a second overflow and carry pair that describe the low 32-bit half of the operation. An execution unit sends the operands and the result of an add or subtract, an overflow indication vector, and a single overflow bit from the multiply or divide path. It also sends strobes that say which flags the current operation updates. The block works out the new flags from these inputs. It does not perform any arithmetic itself.

A narrow-mode input says that the datapath runs 32-bit code. In narrow mode both flag pairs describe the low half. An extension enable controls the half-width pair. When the enable is low, updates leave that pair untouched and reads show it as zero.

Software-visible state is read and written as one flag word, which also keeps the bits that do not hold flags. A 4-bit condition output gives the two overflow bits and the two carry bits in a fixed order. Both outputs are registered and show the post-update state on the same edge that changes the flags.

Top module: `xflag_unit`

## Requirements
- R1: A synchronous active-high reset clears every flag, the stored word, `rd_data` and `cond_out` to zero.
- R2: Add (`sub_sel`=0), wide mode, `upd_ca`: CA becomes the carry out of the top bit of `op_a`+`op_b`, given by `(a[63]&b[63]) | ((a[63]|b[63]) & ~res[63])`. With `ext_en`, CA32 becomes bit 32 of `op_a ^ op_b ^ op_res`.
- R3: Subtract (`sub_sel`=1, result = `op_b` − `op_a`): CA uses `~a[63]` in place of `a[63]` in the R2 formula. CA32 becomes bit 32 of `~(op_a ^ op_b) ^ op_res`.
- R4: Wide mode, `upd_ov`: OV becomes `ov_vec[63]`. With `ext_en`, OV32 becomes `ov_vec[31]`.
- R5: Narrow mode, `upd_ov`: OV becomes `ov_vec[31]`. With `ext_en`, OV32 becomes equal to OV.
- R6: Narrow mode, `upd_ca`: CA becomes the half-width carry term (bit 32 of the R2/R3 XOR or XNOR term), and the top bits are ignored. With `ext_en`, CA32 becomes equal to CA.
- R7: Summary overflow is sticky. Every overflow update ORs the new OV into SO. Only a write or a reset clears SO.
- R8: `upd_md` sets OV to `md_ov` and, with `ext_en`, sets OV32 to `md_ov`. It takes precedence over `upd_ov` and also ORs into SO.
- R9: While `ext_en` is low, updates do not change OV32 or CA32.
- R10: `wr_en` loads SO, OV, CA, OV32 and CA32 from bits 31, 30, 29, 19 and 18 of `wr_data`. It stores the other bits with those five positions cleared. It does this whatever the value of `ext_en`, and it overrides every update strobe in the same cycle.
- R11: `rd_data` shows the stored bits with SO, OV and CA at bits 31, 30 and 29. It shows OV32 and CA32 at bits 19 and 18 only while `ext_en` is high, and zero there otherwise. Both outputs show the state written on the same edge.
- R12: `cond_out` is {OV, OV32, CA, CA32}, most significant bit first, and is not masked by `ext_en`.
- R13: With no strobe asserted, all flags and the stored word hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand (subtrahend for subtract) |
| op_b | input | 64 | Second operand |
| op_res | input | 64 | Result from the adder |
| sub_sel | input | 1 | 1: result is op_b − op_a |
| narrow | input | 1 | 32-bit mode |
| ext_en | input | 1 | Enables the half-width flag pair |
| ov_vec | input | 64 | Overflow indication vector from the add path |
| md_ov | input | 1 | Overflow from multiply or divide |
| upd_ca | input | 1 | Update the carry flags |
| upd_ov | input | 1 | Update the overflow flags from ov_vec |
| upd_md | input | 1 | Update the overflow flags from md_ov |
| wr_en | input | 1 | Load the flag word |
| wr_data | input | 32 | Flag word to load |
| rd_data | output | 32 | Registered flag word |
| cond_out | output | 4 | Registered {OV, OV32, CA, CA32} |

## Verification
The bench builds the block with its defaults: a 64-bit datapath, a 32-bit flag word and the flag positions listed above. This is the only width at which carry out of the top bit and carry out of the low half are distinct bits. The stimulus can therefore make CA and CA32 disagree, and make OV and OV32 disagree, in both modes. The chosen operands separate the XOR and XNOR forms of the half-carry term and show that narrow mode ignores the top bits. The 32-bit word puts all five flag positions and the stored bits within reach of one write and read pair.

// File: rtl/xflag_pkg.sv
package xflag_pkg;

  typedef struct packed {
    logic so;
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } xflags_t;

  localparam int unsigned DEF_SO_BIT   = 31;
  localparam int unsigned DEF_OV_BIT   = 30;
  localparam int unsigned DEF_CA_BIT   = 29;
  localparam int unsigned DEF_OV32_BIT = 19;
  localparam int unsigned DEF_CA32_BIT = 18;

endpackage

// File: rtl/xflag_carry.sv
// Carry flag candidates from operand, result and operation type.
module xflag_carry #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_res,
  input  logic              sub_sel,
  input  logic              narrow,
  output logic              ca_new,
  output logic              ca32_new
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned TOP    = DATA_W - 1;

  logic a_top_eff;
  logic top_carry;
  logic half_carry;

  // A subtract feeds the inverted first operand into the adder.
  assign a_top_eff  = op_a[TOP] ^ sub_sel;
  assign top_carry  = (a_top_eff & op_b[TOP]) |
                      ((a_top_eff | op_b[TOP]) & ~op_res[TOP]);
  // Carry into bit HALF_W: XOR term for add, XNOR term for subtract.
  assign half_carry = op_a[HALF_W] ^ op_b[HALF_W] ^ op_res[HALF_W] ^ sub_sel;

  assign ca_new   = narrow ? half_carry : top_carry;
  assign ca32_new = half_carry;

  logic unused_bits;
  assign unused_bits = ^{op_a[TOP-1:HALF_W+1], op_a[HALF_W-1:0],
                         op_b[TOP-1:HALF_W+1], op_b[HALF_W-1:0],
                         op_res[TOP-1:HALF_W+1], op_res[HALF_W-1:0]};

endmodule

// File: rtl/xflag_ovsel.sv
// Overflow flag candidates from the add path vector or the mul/div bit.
module xflag_ovsel #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] ov_vec,
  input  logic              md_ov,
  input  logic              use_md,
  input  logic              narrow,
  output logic              ov_new,
  output logic              ov32_new
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned TOP    = DATA_W - 1;

  logic half_ov;
  logic wide_ov;

  assign half_ov = ov_vec[HALF_W-1];
  assign wide_ov = narrow ? half_ov : ov_vec[TOP];

  always_comb begin
    if (use_md) begin
      ov_new   = md_ov;
      ov32_new = md_ov;
    end else begin
      ov_new   = wide_ov;
      ov32_new = half_ov;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{ov_vec[TOP-1:HALF_W], ov_vec[HALF_W-2:0]};

endmodule

// File: rtl/xflag_word.sv
// Unpacks a written flag word and packs the state into a read word.
module xflag_word
  import xflag_pkg::*;
#(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned SO_BIT   = DEF_SO_BIT,
  parameter int unsigned OV_BIT   = DEF_OV_BIT,
  parameter int unsigned CA_BIT   = DEF_CA_BIT,
  parameter int unsigned OV32_BIT = DEF_OV32_BIT,
  parameter int unsigned CA32_BIT = DEF_CA32_BIT
) (
  input  logic [REG_W-1:0] wr_data,
  output xflags_t          wr_flags,
  output logic [REG_W-1:0] wr_rest,
  input  xflags_t          st,
  input  logic [REG_W-1:0] rest,
  input  logic             ext_en,
  output logic [REG_W-1:0] rd_word
);
  localparam logic [REG_W-1:0] ONE = {{(REG_W-1){1'b0}}, 1'b1};
  localparam logic [REG_W-1:0] FLAG_MASK = (ONE << SO_BIT) | (ONE << OV_BIT) |
                                           (ONE << CA_BIT) | (ONE << OV32_BIT) |
                                           (ONE << CA32_BIT);

  assign wr_flags.so   = wr_data[SO_BIT];
  assign wr_flags.ov   = wr_data[OV_BIT];
  assign wr_flags.ov32 = wr_data[OV32_BIT];
  assign wr_flags.ca   = wr_data[CA_BIT];
  assign wr_flags.ca32 = wr_data[CA32_BIT];
  assign wr_rest       = wr_data & ~FLAG_MASK;

  always_comb begin
    rd_word           = rest & ~FLAG_MASK;
    rd_word[SO_BIT]   = st.so;
    rd_word[OV_BIT]   = st.ov;
    rd_word[CA_BIT]   = st.ca;
    rd_word[OV32_BIT] = ext_en & st.ov32;
    rd_word[CA32_BIT] = ext_en & st.ca32;
  end

endmodule

// File: rtl/xflag_unit.sv
module xflag_unit
  import xflag_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned SO_BIT   = DEF_SO_BIT,
  parameter int unsigned OV_BIT   = DEF_OV_BIT,
  parameter int unsigned CA_BIT   = DEF_CA_BIT,
  parameter int unsigned OV32_BIT = DEF_OV32_BIT,
  parameter int unsigned CA32_BIT = DEF_CA32_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_res,
  input  logic              sub_sel,
  input  logic              narrow,
  input  logic              ext_en,
  input  logic [DATA_W-1:0] ov_vec,
  input  logic              md_ov,
  input  logic              upd_ca,
  input  logic              upd_ov,
  input  logic              upd_md,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [3:0]        cond_out
);
  localparam int unsigned COND_W = 4;

  xflags_t            st_q, st_n, wr_flags;
  logic [REG_W-1:0]   rest_q, rest_n, wr_rest, rd_n, rd_q;
  logic [COND_W-1:0]  cond_q;
  logic               ca_new, ca32_new, ov_new, ov32_new;

  xflag_carry #(.DATA_W(DATA_W)) u_carry (
    .op_a     (op_a),
    .op_b     (op_b),
    .op_res   (op_res),
    .sub_sel  (sub_sel),
    .narrow   (narrow),
    .ca_new   (ca_new),
    .ca32_new (ca32_new)
  );

  xflag_ovsel #(.DATA_W(DATA_W)) u_ovsel (
    .ov_vec   (ov_vec),
    .md_ov    (md_ov),
    .use_md   (upd_md),
    .narrow   (narrow),
    .ov_new   (ov_new),
    .ov32_new (ov32_new)
  );

  xflag_word #(
    .REG_W(REG_W), .SO_BIT(SO_BIT), .OV_BIT(OV_BIT), .CA_BIT(CA_BIT),
    .OV32_BIT(OV32_BIT), .CA32_BIT(CA32_BIT)
  ) u_word (
    .wr_data  (wr_data),
    .wr_flags (wr_flags),
    .wr_rest  (wr_rest),
    .st       (st_n),
    .rest     (rest_n),
    .ext_en   (ext_en),
    .rd_word  (rd_n)
  );

  // Next state: a write overrides all updates; mul/div overflow beats add overflow.
  always_comb begin
    st_n   = st_q;
    rest_n = rest_q;
    if (wr_en) begin
      st_n   = wr_flags;
      rest_n = wr_rest;
    end else begin
      if (upd_ca) begin
        st_n.ca = ca_new;
        if (ext_en) st_n.ca32 = ca32_new;
      end
      if (upd_md || upd_ov) begin
        st_n.ov = ov_new;
        st_n.so = st_q.so | ov_new;
        if (ext_en) st_n.ov32 = ov32_new;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      rest_q <= '0;
      rd_q   <= '0;
      cond_q <= '0;
    end else begin
      st_q   <= st_n;
      rest_q <= rest_n;
      rd_q   <= rd_n;
      cond_q <= {st_n.ov, st_n.ov32, st_n.ca, st_n.ca32};
    end
  end

  assign rd_data  = rd_q;
  assign cond_out = cond_q;

endmodule

// File: rtl/xflag_unit_chk.sv
module xflag_unit_chk
  import xflag_pkg::*;
#(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned OV_BIT   = DEF_OV_BIT,
  parameter int unsigned CA_BIT   = DEF_CA_BIT,
  parameter int unsigned OV32_BIT = DEF_OV32_BIT,
  parameter int unsigned CA32_BIT = DEF_CA32_BIT
) (
  input logic             clk,
  input logic             rst,
  input logic             ext_en,
  input logic             narrow,
  input logic             wr_en,
  input logic             upd_ca,
  input logic             upd_ov,
  input logic             upd_md,
  input xflags_t          st,
  input logic [REG_W-1:0] rd_data,
  input logic [3:0]       cond_out
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  always_ff @(posedge clk) begin
    if (rst_d) begin
      reset_state_chk: assert (st == '0 && rd_data == '0 && cond_out == '0)
        else $error("reset state not clear");
    end
  end

  // R7
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st.so && !wr_en) |=> st.so);

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en || upd_ca || upd_ov || upd_md) |=> $stable(st));

  // R9
  ext_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ext_en && !wr_en) |=> $stable({st.ov32, st.ca32}));

  // R5
  narrow_ov_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_ov && !upd_md && !wr_en && narrow && ext_en) |=> (st.ov == st.ov32));

  // R12
  cond_word_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_out[3] == rd_data[OV_BIT]) && (cond_out[1] == rd_data[CA_BIT]));

  // R11
  ext_read_chk: assert property (@(posedge clk) disable iff (rst)
    ext_en |=> (cond_out[2] == rd_data[OV32_BIT]) && (cond_out[0] == rd_data[CA32_BIT]));

  // R11
  ext_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> (!rd_data[OV32_BIT] && !rd_data[CA32_BIT]));

endmodule

bind xflag_unit xflag_unit_chk #(
  .REG_W(REG_W), .OV_BIT(OV_BIT), .CA_BIT(CA_BIT),
  .OV32_BIT(OV32_BIT), .CA32_BIT(CA32_BIT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ext_en   (ext_en),
  .narrow   (narrow),
  .wr_en    (wr_en),
  .upd_ca   (upd_ca),
  .upd_ov   (upd_ov),
  .upd_md   (upd_md),
  .st       (st_q),
  .rd_data  (rd_data),
  .cond_out (cond_out)
);

// File: tb/xflag_unit_bench.sv
`timescale 1ns/1ps
module xflag_unit_bench;
  localparam int DW = 64;
  localparam int RW = 32;
  localparam int NV = 14;

  typedef struct packed {
    logic          nar;
    logic          ext;
    logic          sub;
    logic [63:0]   a;
    logic [63:0]   b;
    logic [63:0]   r;
    logic [63:0]   ovv;
    logic          uca;
    logic          uov;
    logic [3:0]    ecd;
    logic          eso;
  } vec_t;

  localparam vec_t VT [0:NV-1] = '{
    '{1'b0,1'b1,1'b0,64'h0000_0000_FFFF_FFFF,64'h1,64'h0000_0001_0000_0000,64'h0,1'b1,1'b0,4'b0001,1'b0},
    '{1'b0,1'b1,1'b0,64'hFFFF_FFFF_FFFF_FFFF,64'h1,64'h0,64'h0,1'b1,1'b0,4'b0011,1'b0},
    '{1'b0,1'b1,1'b1,64'h1,64'h0000_0001_0000_0000,64'h0000_0000_FFFF_FFFF,64'h0,1'b1,1'b0,4'b0010,1'b0},
    '{1'b0,1'b1,1'b1,64'h1,64'h2,64'h1,64'h0,1'b1,1'b0,4'b0011,1'b0},
    '{1'b0,1'b1,1'b0,64'h0,64'h0,64'h0,64'h8000_0000_0000_0000,1'b0,1'b1,4'b1000,1'b1},
    '{1'b0,1'b1,1'b0,64'h0,64'h0,64'h0,64'h0000_0000_8000_0000,1'b0,1'b1,4'b0100,1'b0},
    '{1'b1,1'b1,1'b0,64'h0,64'h0,64'h0,64'h0000_0000_8000_0000,1'b0,1'b1,4'b1100,1'b1},
    '{1'b1,1'b1,1'b0,64'h0,64'h0,64'h0,64'h8000_0000_0000_0000,1'b0,1'b1,4'b0000,1'b0},
    '{1'b1,1'b1,1'b0,64'h0000_0000_FFFF_FFFF,64'h1,64'h0000_0001_0000_0000,64'h0,1'b1,1'b0,4'b0011,1'b0},
    '{1'b1,1'b1,1'b0,64'hFFFF_FFFF_0000_0001,64'hFFFF_FFFF_0000_0001,64'hFFFF_FFFE_0000_0002,64'h0,1'b1,1'b0,4'b0000,1'b0},
    '{1'b1,1'b1,1'b1,64'h1,64'h2,64'h1,64'h0,1'b1,1'b0,4'b0011,1'b0},
    '{1'b0,1'b0,1'b0,64'hFFFF_FFFF_FFFF_FFFF,64'h1,64'h0,64'h0,1'b1,1'b0,4'b0010,1'b0},
    '{1'b1,1'b0,1'b0,64'h0,64'h0,64'h0,64'h0000_0000_8000_0000,1'b0,1'b1,4'b1000,1'b1},
    '{1'b0,1'b1,1'b0,64'hFFFF_FFFF_FFFF_FFFF,64'h1,64'h0,64'h8000_0000_0000_0000,1'b1,1'b1,4'b1011,1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] op_a = '0, op_b = '0, op_res = '0, ov_vec = '0;
  logic          sub_sel = 1'b0, narrow = 1'b0, ext_en = 1'b0, md_ov = 1'b0;
  logic          upd_ca = 1'b0, upd_ov = 1'b0, upd_md = 1'b0, wr_en = 1'b0;
  logic [RW-1:0] wr_data = '0;
  logic [RW-1:0] rd_data;
  logic [3:0]    cond_out;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  xflag_unit u_xflag_unit (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_res(op_res),
    .sub_sel(sub_sel), .narrow(narrow), .ext_en(ext_en), .ov_vec(ov_vec),
    .md_ov(md_ov), .upd_ca(upd_ca), .upd_ov(upd_ov), .upd_md(upd_md),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .cond_out(cond_out)
  );

  task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    upd_ca = 1'b0; upd_ov = 1'b0; upd_md = 1'b0; wr_en = 1'b0;
  endtask

  task automatic write_word(logic [RW-1:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
  endtask

  function automatic logic [RW-1:0] exp_word(logic so, logic [3:0] cd, logic ext);
    logic [RW-1:0] w = '0;
    w[31] = so; w[30] = cd[3]; w[29] = cd[1];
    w[19] = ext & cd[2]; w[18] = ext & cd[0];
    return w;
  endfunction

  function automatic string vtag(int i);
    case (i)
      0, 1, 13: return "R2";
      2, 3:     return "R3";
      4, 5:     return "R4";
      6, 7:     return "R5";
      8, 9, 10: return "R6";
      default:  return "R9";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: state under reset
    check_eq("R1 rd_data", rd_data, 0);
    check_eq("R1 cond_out", cond_out, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ext_en = VT[i].ext;
      write_word('0);
      narrow = VT[i].nar; sub_sel = VT[i].sub;
      op_a = VT[i].a; op_b = VT[i].b; op_res = VT[i].r; ov_vec = VT[i].ovv;
      upd_ca = VT[i].uca; upd_ov = VT[i].uov;
      tick();
      check_eq({vtag(i), " R12 cond"}, cond_out, VT[i].ecd);
      check_eq({vtag(i), " R7 R11 word"}, rd_data,
               exp_word(VT[i].eso, VT[i].ecd, VT[i].ext));
    end

    // R7: SO stays after OV clears
    narrow = 1'b0; ext_en = 1'b1; sub_sel = 1'b0;
    op_a = '0; op_b = '0; op_res = '0;
    write_word('0);
    ov_vec = 64'h8000_0000_0000_0000; upd_ov = 1'b1; tick();
    ov_vec = '0; upd_ov = 1'b1; tick();
    check_eq("R7 sticky word", rd_data, 32'h8000_0000);
    check_eq("R7 sticky cond", cond_out, 4'b0000);

    // R8: mul/div overflow, beats add overflow, both ext settings
    write_word('0);
    md_ov = 1'b1; upd_md = 1'b1; upd_ov = 1'b1; ov_vec = '0; tick();
    check_eq("R8 md cond ext", cond_out, 4'b1100);
    check_eq("R8 md word ext", rd_data, 32'hC008_0000);
    ext_en = 1'b0;
    write_word('0);
    md_ov = 1'b1; upd_md = 1'b1; tick();
    check_eq("R8 md cond no ext", cond_out, 4'b1000);
    md_ov = 1'b0;

    // R10 R11: write all ones, read with and without extension
    ext_en = 1'b1;
    write_word(32'hFFFF_FFFF);
    check_eq("R10 word all ones", rd_data, 32'hFFFF_FFFF);
    check_eq("R12 cond all ones", cond_out, 4'b1111);
    ext_en = 1'b0; tick();
    check_eq("R11 masked word", rd_data, 32'hFFF3_FFFF);
    check_eq("R12 cond unmasked", cond_out, 4'b1111);
    write_word(32'h0000_1234);
    check_eq("R10 stored bits", rd_data, 32'h0000_1234);
    check_eq("R10 flags cleared", cond_out, 4'b0000);

    // R10: write wins over update strobes in the same cycle
    ext_en = 1'b1;
    op_a = '1; op_b = 64'h1; op_res = '0; ov_vec = 64'h8000_0000_8000_0000;
    wr_en = 1'b1; wr_data = 32'h4000_0000; upd_ca = 1'b1; upd_ov = 1'b1;
    tick();
    check_eq("R10 write priority word", rd_data, 32'h4000_0000);
    check_eq("R10 write priority cond", cond_out, 4'b1000);

    // R9: half-width pair untouched while extension off
    ext_en = 1'b0;
    write_word(32'h000C_0000);
    op_a = '0; op_b = '0; op_res = '0; ov_vec = '0; narrow = 1'b1;
    upd_ca = 1'b1; upd_ov = 1'b1; tick();
    ext_en = 1'b1; narrow = 1'b0; tick();
    check_eq("R9 pair kept word", rd_data, 32'h000C_0000);
    check_eq("R9 pair kept cond", cond_out, 4'b0101);

    // R13: hold with idle strobes and changing data inputs
    write_word(32'hE00C_0000);
    for (int k = 0; k < 5; k++) begin
      op_a = {2{32'hA5A5_0000 + k}}; op_b = ~op_a; op_res = '1; ov_vec = '1;
      md_ov = 1'b1; sub_sel = k[0];
      tick();
    end
    check_eq("R13 hold word", rd_data, 32'hE00C_0000);
    check_eq("R13 hold cond", cond_out, 4'b1111);

    // R1: reset during operation
    rst = 1'b1; tick();
    check_eq("R1 word after reset", rd_data, 0);
    check_eq("R1 cond after reset", cond_out, 0);
    rst = 1'b0; tick();
    check_eq("R1 word stays clear", rd_data, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule